// File: doc/BRIEF.md
# Register-Pointer Serial Target Interface

This block is the target side of a two-wire serial bus (I2C), run from a fast system clock that oversamples the bus lines. It recognises start, repeated start and stop conditions, answers to one of two 7-bit device addresses picked by a strap input, and keeps a 5-bit register pointer. A host writes the pointer and then any number of data bytes, or reads bytes back. The pointer advances after every byte in either direction.

Toward the chip the block offers a write strobe with address and data for each received byte. It also offers a read strobe with an address. The register bank answers the read strobe with a byte on `rd_data` in the same clock cycle. The bank itself lives outside this block. SDA is open-drain: the block only asserts a pull-low enable, and the bus level comes back through `sda_i`.

The pointer space ends at 13h: the byte after 13h goes to 00h. A read with no pointer phase resumes one past the last register touched. Any byte cut short by a start or stop condition is dropped.

Top module: `i2c_ptr_target`

## Requirements
- R1: The device address is 7'b0001001 when `addr_sel` is 0 and 7'b0001110 when it is 1. A byte holding any other address gets no acknowledge, and the rest of that transfer causes no strobe.
- R2: The eighth bit of the address byte selects the direction. 0 starts a write (pointer byte, then data) and 1 starts a read.
- R3: After reset, and after every stop condition, SDA is released (`sda_pull` = 0) and no strobe is active. A start (SDA falls while SCL is high) that is followed directly by a stop (SDA rises while SCL is high) produces no strobe.
- R4: In a write, the low 5 bits of the first byte after the address load the pointer. Each later byte produces a one-cycle `wr_stb` with `wr_addr` equal to the pointer and `wr_data` equal to the byte, and then the pointer advances.
- R5: The pointer advances from 13h to 00h, for writes and reads alike.
- R6: A read started with no pointer phase begins at the register after the last one written or read.
- R7: A pointer write, then a repeated start, then a read address, returns data beginning at the written pointer, with auto-increment.
- R8: A start or stop condition in the middle of a data byte or of the address byte discards that byte, so no `wr_stb` is produced for it.
- R9: The target pulls SDA low during the ninth clock after a matched address and after each received pointer or data byte. If the host leaves SDA high in the ninth clock after a read byte, the read ends and no further `rd_stb` follows.
- R10: One `rd_stb` fires at the acknowledge clock before each transmitted byte. The byte then sent, MSB first, equals `rd_data` at that strobe.
- R11: `sda_pull` changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_sel | input | 1 | Strap selecting one of the two device addresses |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| sda_pull | output | 1 | When 1, the pad pulls SDA low |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_addr | output | 5 | Register address for the write strobe |
| wr_data | output | 8 | Byte for the write strobe |
| rd_stb | output | 1 | One-cycle fetch request |
| rd_addr | output | 5 | Register address to fetch |
| rd_data | input | 8 | Register byte, valid in the `rd_stb` cycle |

## Verification
The bench sweeps both strap values. For each one it writes bursts that cross the 13h boundary, reads them back through a combined transfer, and then continues with a plain read. A design that missed the wrap would write into 14h and read back stale bytes. A design that reset the pointer on a plain read would return data from 00h. The bench also cuts a data byte with a stop and an address byte with a repeated start, sends a bare start-stop pair and addresses the wrong device. Each of these must leave the register model untouched and raise no strobe, and a design that latched partial bytes would corrupt a register. Strobe counts are matched against bytes moved, so an extra fetch after a host NACK is caught.

// File: rtl/i2cp_pkg.sv
package i2cp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RD_ACK
  } eng_state_t;

  localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/i2cp_deglitch.sv
// Two-flop synchronizer followed by a majority vote over a short window.
module i2cp_deglitch #(
  parameter int unsigned WIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic flt_o
);
  localparam int unsigned HALF = WIN / 2;

  logic [1:0]     sync_q;
  logic [WIN-1:0] win_q;
  logic           out_q, out_d;

  always_comb begin
    out_d = ($countones(win_q) > HALF);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], raw_i};
      win_q  <= {win_q[WIN-2:0], sync_q[1]};
      out_q  <= out_d;
    end
  end

  assign flt_o = out_q;
endmodule

// File: rtl/i2cp_cond.sv
// Bus condition and clock edge detection on filtered lines.
module i2cp_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_o,
  output logic stop_o,
  output logic rise_o,
  output logic fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  assign start_o = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_o  = scl_f & scl_q & ~sda_q & sda_f;
  assign rise_o  = scl_f & ~scl_q;
  assign fall_o  = ~scl_f & scl_q;
endmodule

// File: rtl/i2cp_engine.sv
// Byte-level protocol engine: address match, pointer, strobes, SDA drive.
module i2cp_engine
  import i2cp_pkg::*;
#(
  parameter int unsigned          AW        = 5,
  parameter logic [AW-1:0]        LAST_ADDR = 5'h13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [6:0]           dev_addr,
  input  logic                 sda_f,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic                 rise_i,
  input  logic                 fall_i,
  output logic                 sda_pull,
  output logic                 wr_stb,
  output logic [AW-1:0]        wr_addr,
  output logic [BYTE_W-1:0]    wr_data,
  output logic                 rd_stb,
  output logic [AW-1:0]        rd_addr,
  input  logic [BYTE_W-1:0]    rd_data,
  output logic [AW-1:0]        ptr_o
);
  localparam logic [3:0] FULL = 4'(BYTE_W);

  eng_state_t         state_q, state_d;
  logic [3:0]         cnt_q, cnt_d;
  logic [BYTE_W-1:0]  sh_q, sh_d;
  logic [BYTE_W-1:0]  tx_q, tx_d;
  logic [AW-1:0]      ptr_q, ptr_d;
  logic               rw_q, rw_d;
  logic               nack_q, nack_d;
  logic               pull_q, pull_d;
  logic               wst_q, wst_d;
  logic [AW-1:0]      wad_q, wad_d;
  logic [BYTE_W-1:0]  wdt_q, wdt_d;
  logic               fetch;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST_ADDR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    tx_d    = tx_q;
    ptr_d   = ptr_q;
    rw_d    = rw_q;
    nack_d  = nack_q;
    pull_d  = pull_q;
    wst_d   = 1'b0;
    wad_d   = wad_q;
    wdt_d   = wdt_q;
    fetch   = 1'b0;

    unique case (state_q)
      ST_ADDR, ST_PTR, ST_WDATA: begin
        if (rise_i && (cnt_q < FULL)) begin
          sh_d  = {sh_q[BYTE_W-2:0], sda_f};
          cnt_d = cnt_q + 4'd1;
        end else if (fall_i && (cnt_q == FULL)) begin
          if (state_q == ST_ADDR) begin
            if (sh_q[7:1] == dev_addr) begin
              rw_d    = sh_q[0];
              pull_d  = 1'b1;
              state_d = ST_ADDR_ACK;
            end else begin
              state_d = ST_IDLE;
            end
          end else if (state_q == ST_PTR) begin
            ptr_d   = sh_q[AW-1:0];
            pull_d  = 1'b1;
            state_d = ST_PTR_ACK;
          end else begin
            wst_d   = 1'b1;
            wad_d   = ptr_q;
            wdt_d   = sh_q;
            ptr_d   = bump(ptr_q);
            pull_d  = 1'b1;
            state_d = ST_WDATA_ACK;
          end
        end
      end
      ST_ADDR_ACK: begin
        if (fall_i) begin
          if (rw_q) begin
            fetch = 1'b1;
          end else begin
            pull_d  = 1'b0;
            cnt_d   = '0;
            state_d = ST_PTR;
          end
        end
      end
      ST_PTR_ACK, ST_WDATA_ACK: begin
        if (fall_i) begin
          pull_d  = 1'b0;
          cnt_d   = '0;
          state_d = ST_WDATA;
        end
      end
      ST_RDATA: begin
        if (rise_i) begin
          cnt_d = cnt_q + 4'd1;
        end else if (fall_i) begin
          if (cnt_q == FULL) begin
            pull_d  = 1'b0;
            state_d = ST_RD_ACK;
          end else begin
            tx_d   = {tx_q[BYTE_W-2:0], 1'b0};
            pull_d = ~tx_q[BYTE_W-2];
          end
        end
      end
      ST_RD_ACK: begin
        if (rise_i) begin
          nack_d = sda_f;
        end else if (fall_i) begin
          if (nack_q) begin
            state_d = ST_IDLE;
          end else begin
            fetch = 1'b1;
          end
        end
      end
      default: ;
    endcase

    if (fetch) begin
      tx_d    = rd_data;
      pull_d  = ~rd_data[BYTE_W-1];
      ptr_d   = bump(ptr_q);
      cnt_d   = '0;
      state_d = ST_RDATA;
    end

    if (start_i) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      pull_d  = 1'b0;
    end else if (stop_i) begin
      state_d = ST_IDLE;
      pull_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      tx_q    <= '0;
      ptr_q   <= '0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b0;
      pull_q  <= 1'b0;
      wst_q   <= 1'b0;
      wad_q   <= '0;
      wdt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      tx_q    <= tx_d;
      ptr_q   <= ptr_d;
      rw_q    <= rw_d;
      nack_q  <= nack_d;
      pull_q  <= pull_d;
      wst_q   <= wst_d;
      wad_q   <= wad_d;
      wdt_q   <= wdt_d;
    end
  end

  assign sda_pull = pull_q;
  assign wr_stb   = wst_q;
  assign wr_addr  = wad_q;
  assign wr_data  = wdt_q;
  assign rd_stb   = fetch & ~start_i & ~stop_i;
  assign rd_addr  = ptr_q;
  assign ptr_o    = ptr_q;
endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target #(
  parameter int unsigned   AW        = 5,
  parameter int unsigned   FILT_WIN  = 3,
  parameter logic [AW-1:0] LAST_ADDR = 5'h13,
  parameter logic [6:0]    DEV_ADDR0 = 7'b0001001,
  parameter logic [6:0]    DEV_ADDR1 = 7'b0001110
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          addr_sel,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_pull,
  output logic          wr_stb,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_stb,
  output logic [AW-1:0] rd_addr,
  input  logic [7:0]    rd_data
);
  localparam int unsigned NLINES = 2;

  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [NLINES-1:0] raw_lines, flt_lines;
  logic              scl_flt, sda_flt;
  logic              start_det, stop_det, scl_rise, scl_fall;
  logic [6:0]        dev_addr;
  logic [AW-1:0]     cur_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    i2cp_deglitch #(.WIN(FILT_WIN)) u_flt (
      .clk   (clk),
      .rst_n (rst_int_n),
      .raw_i (raw_lines[g]),
      .flt_o (flt_lines[g])
    );
  end

  assign scl_flt  = flt_lines[0];
  assign sda_flt  = flt_lines[1];
  assign dev_addr = addr_sel ? DEV_ADDR1 : DEV_ADDR0;

  i2cp_cond u_cond (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .scl_f   (scl_flt),
    .sda_f   (sda_flt),
    .start_o (start_det),
    .stop_o  (stop_det),
    .rise_o  (scl_rise),
    .fall_o  (scl_fall)
  );

  i2cp_engine #(.AW(AW), .LAST_ADDR(LAST_ADDR)) u_eng (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .dev_addr (dev_addr),
    .sda_f    (sda_flt),
    .start_i  (start_det),
    .stop_i   (stop_det),
    .rise_i   (scl_rise),
    .fall_i   (scl_fall),
    .sda_pull (sda_pull),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_stb   (rd_stb),
    .rd_addr  (rd_addr),
    .rd_data  (rd_data),
    .ptr_o    (cur_ptr)
  );
endmodule

// File: rtl/i2cp_checker.sv
module i2cp_checker #(
  parameter int unsigned   AW        = 5,
  parameter logic [AW-1:0] LAST_ADDR = 5'h13
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_f,
  input logic          stop_det,
  input logic          sda_pull,
  input logic          wr_stb,
  input logic [AW-1:0] wr_addr,
  input logic          rd_stb,
  input logic [AW-1:0] rd_addr,
  input logic [AW-1:0] ptr
);
  p_pull_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !scl_f);

  p_stop_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_pull);

  p_wr_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);

  p_rd_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb);

  p_no_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb));

  p_wr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && wr_addr == LAST_ADDR) |-> (ptr == '0));

  p_rd_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && rd_addr == LAST_ADDR) |=> (ptr == '0));
endmodule

bind i2c_ptr_target i2cp_checker #(.AW(AW), .LAST_ADDR(LAST_ADDR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .scl_f    (scl_flt),
  .stop_det (stop_det),
  .sda_pull (sda_pull),
  .wr_stb   (wr_stb),
  .wr_addr  (wr_addr),
  .rd_stb   (rd_stb),
  .rd_addr  (rd_addr),
  .ptr      (cur_ptr)
);

// File: tb/sim_i2c_ptr_target.sv
module sim_i2c_ptr_target;
  localparam int Q    = 12;
  localparam int NREG = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_sel = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_bus;
  logic       sda_pull;
  logic       wr_stb, rd_stb;
  logic [4:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;

  logic [7:0] bank [32];
  logic [7:0] expv [32];
  int total = 0, bad = 0;
  int n_wr = 0, n_rd = 0, n_hi_chg = 0;
  logic pull_prev = 1'b0;

  always #10 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull;
  assign rd_data = bank[rd_addr];

  i2c_ptr_target u0 (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_pull(sda_pull),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) bank[i] <= 8'(8'hA5 ^ (i * 13));
    end else begin
      if (wr_stb) begin
        bank[wr_addr] <= wr_data;
        n_wr <= n_wr + 1;
      end
      if (rd_stb) n_rd <= n_rd + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && (sda_pull != pull_prev) && scl_m) n_hi_chg <= n_hi_chg + 1;
    pull_prev <= sda_pull;
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q);
    sda_m = 1'b0; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(Q); scl_m = 1'b1; wt(Q);
    sda_m = 1'b1; wt(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wt(Q); scl_m = 1'b1; wt(Q); scl_m = 1'b0; wt(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wt(Q); scl_m = 1'b1; wt(Q / 2);
    b = sda_bus; wt(Q / 2); scl_m = 1'b0; wt(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack);
  endtask

  task automatic get_byte(input logic last, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(last);
  endtask

  function automatic logic [6:0] dev(input logic s);
    return s ? 7'b0001110 : 7'b0001001;
  endfunction

  function automatic int wrapa(input int a);
    return a % NREG;
  endfunction

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic ack;
    logic [7:0] v;
    int w0, r0;
    for (int i = 0; i < 32; i++) expv[i] = 8'(8'hA5 ^ (i * 13));
    wt(5); rst_n = 1'b1; wt(10);
    chk("R3 reset pull", int'(sda_pull), 0);
    chk("R3 reset strobes", int'(wr_stb | rd_stb), 0);

    for (int s = 0; s < 2; s++) begin
      addr_sel = s[0];
      wt(20);

      // wrong device: no ack, no strobe
      w0 = n_wr;
      bus_start; put_byte({dev(~s[0]), 1'b0}, ack);
      chk("R1 foreign address nack", int'(ack), 1);
      put_byte(8'h02, ack); put_byte(8'h77, ack); bus_stop;
      chk("R1 foreign address no write", n_wr - w0, 0);

      // burst write crossing 13h
      w0 = n_wr;
      bus_start; put_byte({dev(s[0]), 1'b0}, ack);
      chk("R9 address ack", int'(ack), 0);
      put_byte(8'h11, ack);
      chk("R9 pointer ack", int'(ack), 0);
      for (int k = 0; k < 4; k++) begin
        v = 8'(8'h3C + k * 17 + s);
        put_byte(v, ack);
        chk("R9 data ack", int'(ack), 0);
        expv[wrapa(17 + k)] = v;
      end
      bus_stop;
      chk("R4 write strobe count", n_wr - w0, 4);
      for (int k = 0; k < 4; k++)
        chk("R5 R4 bank after burst", int'(bank[wrapa(17 + k)]), int'(expv[wrapa(17 + k)]));
      chk("R5 no write past 13h", int'(bank[20]), int'(expv[20]));

      // combined read from 11h
      r0 = n_rd;
      bus_start; put_byte({dev(s[0]), 1'b0}, ack); put_byte(8'h11, ack);
      bus_start; put_byte({dev(s[0]), 1'b1}, ack);
      chk("R2 read address ack", int'(ack), 0);
      for (int k = 0; k < 4; k++) begin
        get_byte(k == 3, v);
        chk("R7 R5 combined read", int'(v), int'(expv[wrapa(17 + k)]));
      end
      wt(Q);
      chk("R9 release after nack", int'(sda_pull), 0);
      bus_stop;
      chk("R10 R9 fetch count", n_rd - r0, 4);

      // plain read continues from 01h
      r0 = n_rd;
      bus_start; put_byte({dev(s[0]), 1'b1}, ack);
      get_byte(1'b0, v);
      chk("R6 resume first", int'(v), int'(expv[1]));
      get_byte(1'b1, v);
      chk("R6 resume second", int'(v), int'(expv[2]));
      bus_stop;
      chk("R10 plain fetch count", n_rd - r0, 2);

      // data byte cut by stop
      w0 = n_wr;
      bus_start; put_byte({dev(s[0]), 1'b0}, ack); put_byte(8'h05, ack);
      for (int i = 0; i < 4; i++) put_bit(1'b1);
      bus_stop;
      chk("R8 cut data no strobe", n_wr - w0, 0);

      // bare start then stop
      w0 = n_wr; r0 = n_rd;
      bus_start; bus_stop;
      chk("R3 start-stop no strobe", (n_wr - w0) + (n_rd - r0), 0);

      // address byte cut by repeated start, then valid read at 05h
      bus_start;
      for (int i = 0; i < 3; i++) put_bit(1'b0);
      bus_start; put_byte({dev(s[0]), 1'b1}, ack);
      chk("R8 recovery ack", int'(ack), 0);
      get_byte(1'b1, v);
      chk("R8 pointer kept, bank intact", int'(v), int'(expv[5]));
      bus_stop;
      chk("R8 bank intact", int'(bank[5]), int'(expv[5]));
    end

    chk("R11 sda change while scl high", n_hi_chg, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule